// File: doc/BRIEF.md
# Host Byte-to-Word Assembler

This block joins a narrow host data bus to a 24-bit internal memory bus. The host bus is either 8 or 16 bits wide, as set by a configuration input. The internal word is either 16 or 24 bits, as set by a second configuration input. Each internal word therefore takes one, two or three host accesses. The block splits and joins words in both directions.

On writes, the pieces are collected into an assembly register. One internal write is posted when the last piece of the word arrives. On reads, the first host access of a word starts one internal read. The returned word is then kept, and its pieces are handed out over the following host accesses.

For each host access, the block says when the host may finish it. Pieces that touch no memory are released in the next cycle. The access that starts a read, or that completes a write, is released only after the memory reports completion. Address generation and bus arbitration are done outside this block.

Top module: `host_word_packer`

## Requirements
- R1: The number of pieces per word is set by the two configuration inputs. With `cfg_wide`=0 (8-bit bus) there are 3 pieces if `cfg_word24`=1 and 2 pieces if it is 0. With `cfg_wide`=1 (16-bit bus) there are 2 pieces if `cfg_word24`=1 and 1 piece if it is 0.
- R2: Write pieces are placed least-significant first.
  - On an 8-bit bus, piece k goes to word bits [8k+7:8k].
  - On a 16-bit bus, piece 0 fills word bits [15:0], and bits [15:8] of piece 1 fill word bits [23:16].
  - Word bits that no piece writes are zero.
- R3: Exactly one internal write (`mem_req`=1, `mem_we`=1) is issued per word, when its final piece is accepted. Its request, direction and data stay stable until `mem_done`.
- R4: A read word issues exactly one internal read (`mem_req`=1, `mem_we`=0), on its first piece. Later pieces of that word issue no request.
- R5: Read data is returned on `hst_rdata` in the cycle `hst_ack` is high.
  - On an 8-bit bus, piece k returns {8'h00, word[8k+7:8k]}.
  - On a 16-bit bus, piece 0 returns word[15:0] and piece 1 returns {word[23:16], 8'h00}.
- R6: A piece that neither starts a read nor completes a write is acknowledged in the cycle after it is accepted.
- R7: An access that uses memory is acknowledged in the cycle after `mem_done`. `hst_ack` is never high while `mem_req` is high.
- R8: While `hst_cs` is low, strobes are ignored and the piece counter returns to zero. The next word therefore starts at piece 0.
- R9: A strobe that arrives while an internal access is outstanding is held. It is served once that access completes.
- R10: A strobe whose direction differs from the word in progress restarts assembly at piece 0.
- R11: After reset, `mem_req` and `hst_ack` are low and the next access is piece 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | Host bus width: 0 = 8 bits, 1 = 16 bits |
| cfg_word24 | input | 1 | Internal word size: 0 = 16 bits, 1 = 24 bits |
| hst_cs | input | 1 | Host chip select, active high |
| hst_rd_stb | input | 1 | One-cycle pulse that starts a host read access |
| hst_wr_stb | input | 1 | One-cycle pulse that starts a host write access |
| hst_wdata | input | HOST_W | Host write data |
| hst_ack | output | 1 | One-cycle pulse: the current host access may complete |
| hst_rdata | output | HOST_W | Host read data, valid with `hst_ack` |
| mem_req | output | 1 | Internal access request, held until `mem_done` |
| mem_we | output | 1 | Internal access direction: 1 = write |
| mem_wdata | output | WORD_W | Internal write word |
| mem_rdata | input | WORD_W | Internal read word, valid with `mem_done` |
| mem_done | input | 1 | One-cycle pulse: the internal access has finished |

## Verification
The hardest case to reach is a host strobe that arrives while the posted write of the previous word is still outstanding. A host that waits for each acknowledge never causes this. The stimulus forces it directly. It first stretches the memory latency, then completes a word, then raises the first write strobe of the next word while `mem_req` is still high. It then checks three things: the held piece is acknowledged right after the posted write, the held piece sits in the lowest lane of the next word, and the next word is written correctly. A chip-select drop in the middle of a word and a read that interrupts a partial write are driven the same way. These are followed by randomised full words under every configuration.

// File: rtl/hwp_pkg.sv
package hwp_pkg;

  typedef logic [1:0] pidx_t;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

  // Pieces per internal word for a bus width / word size pair.
  function automatic pidx_t piece_total(input logic wide, input logic word24);
    if (wide) return word24 ? 2'd2 : 2'd1;
    else      return word24 ? 2'd3 : 2'd2;
  endfunction

  // On the wide bus, which host half carries word lane j.
  // A leftover top lane rides in the upper half.
  function automatic int lane_half(input int j, input int nlane);
    return (((j % 2) == 1) || (j == nlane - 1)) ? 1 : 0;
  endfunction

endpackage

// File: rtl/hwp_piece_ctr.sv
module hwp_piece_ctr
  import hwp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs,
  input  logic  adv,
  input  op_e   adv_op,
  input  pidx_t total,
  output pidx_t eff_idx,
  output logic  is_last,
  output pidx_t cnt_q
);

  op_e   dir_q;
  op_e   dir_d;
  pidx_t cnt_d;

  // A change of direction restarts the word at piece 0.
  always_comb begin
    eff_idx = (adv_op != dir_q) ? '0 : cnt_q;
    is_last = (eff_idx == (total - 2'd1));
  end

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (!cs) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = is_last ? '0 : (eff_idx + 2'd1);
      dir_d = adv_op;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= OP_WRITE;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

endmodule

// File: rtl/hwp_wr_pack.sv
module hwp_wr_pack
  import hwp_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wide,
  input  pidx_t             idx,
  input  logic [HOST_W-1:0] wdata,
  output logic [WORD_W-1:0] word_next
);

  localparam int LANE_W = HOST_W / 2;
  localparam int NLANE  = WORD_W / LANE_W;

  logic [WORD_W-1:0] asm_q;
  logic [WORD_W-1:0] asm_d;

  for (genvar j = 0; j < NLANE; j++) begin : g_lane
    localparam int WPIECE = j / 2;
    localparam int WHALF  = lane_half(j, NLANE);
    logic              hit;
    logic [LANE_W-1:0] src;
    logic [LANE_W-1:0] keep;

    assign hit  = wide ? (idx == pidx_t'(WPIECE)) : (idx == pidx_t'(j));
    assign src  = wide ? wdata[WHALF*LANE_W +: LANE_W] : wdata[LANE_W-1:0];
    // Piece 0 starts a fresh word: lanes not written become zero.
    assign keep = (idx == '0) ? '0 : asm_q[j*LANE_W +: LANE_W];
    assign asm_d[j*LANE_W +: LANE_W] = hit ? src : keep;
  end

  assign word_next = asm_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= '0;
    end else if (load) begin
      asm_q <= asm_d;
    end
  end

endmodule

// File: rtl/hwp_rd_unpack.sv
module hwp_rd_unpack
  import hwp_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              serve,
  input  pidx_t             idx,
  input  logic              wide,
  output logic [HOST_W-1:0] rdata_q
);

  localparam int LANE_W = HOST_W / 2;
  localparam int NLANE  = WORD_W / LANE_W;

  logic [WORD_W-1:0] rbuf_q;
  logic [WORD_W-1:0] src;
  pidx_t             sel_idx;
  logic [HOST_W-1:0] wide_v;
  logic [HOST_W-1:0] byte_v;
  logic [HOST_W-1:0] rdata_d;

  // A fresh word from memory always answers with piece 0.
  assign src     = fill ? mem_rdata : rbuf_q;
  assign sel_idx = fill ? '0 : idx;

  always_comb begin
    wide_v = '0;
    byte_v = '0;
    for (int j = 0; j < NLANE; j++) begin
      if (sel_idx == pidx_t'(j / 2))
        wide_v[lane_half(j, NLANE)*LANE_W +: LANE_W] = src[j*LANE_W +: LANE_W];
      if (sel_idx == pidx_t'(j))
        byte_v[LANE_W-1:0] = src[j*LANE_W +: LANE_W];
    end
    rdata_d = wide ? wide_v : byte_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (fill) rbuf_q <= mem_rdata;
      if (fill || serve) rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/hwp_seq.sv
module hwp_seq
  import hwp_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  op_e               stb_op,
  input  logic [HOST_W-1:0] wdata,
  input  logic              issue,
  input  logic              quick,
  input  logic              mem_done,
  input  logic [WORD_W-1:0] word_next,
  output logic              acc,
  output op_e               acc_op,
  output logic [HOST_W-1:0] acc_data,
  output logic              busy_q,
  output logic              pend_v_q,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              ack_q
);

  op_e               pend_op_q;
  logic [HOST_W-1:0] pend_data_q;
  op_e               op_q;
  logic [WORD_W-1:0] wdat_q;

  logic              busy_d;
  op_e               op_d;
  logic [WORD_W-1:0] wdat_d;
  logic              ack_d;
  logic              pend_v_d;
  op_e               pend_op_d;
  logic [HOST_W-1:0] pend_data_d;
  logic              finish;

  // A held strobe is served before any new one.
  assign acc      = !busy_q && (pend_v_q || stb);
  assign acc_op   = pend_v_q ? pend_op_q : stb_op;
  assign acc_data = pend_v_q ? pend_data_q : wdata;
  assign finish   = busy_q && mem_done;

  always_comb begin
    busy_d      = busy_q;
    op_d        = op_q;
    wdat_d      = wdat_q;
    pend_v_d    = pend_v_q;
    pend_op_d   = pend_op_q;
    pend_data_d = pend_data_q;

    if (finish)     busy_d = 1'b0;
    else if (issue) busy_d = 1'b1;

    if (issue) begin
      op_d = acc_op;
      if (acc_op == OP_WRITE) wdat_d = word_next;
    end

    if (busy_q && stb && !pend_v_q) begin
      pend_v_d    = 1'b1;
      pend_op_d   = stb_op;
      pend_data_d = wdata;
    end else if (acc && pend_v_q) begin
      pend_v_d = 1'b0;
    end

    ack_d = quick || finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      op_q        <= OP_READ;
      wdat_q      <= '0;
      ack_q       <= 1'b0;
      pend_v_q    <= 1'b0;
      pend_op_q   <= OP_READ;
      pend_data_q <= '0;
    end else begin
      busy_q      <= busy_d;
      op_q        <= op_d;
      wdat_q      <= wdat_d;
      ack_q       <= ack_d;
      pend_v_q    <= pend_v_d;
      pend_op_q   <= pend_op_d;
      pend_data_q <= pend_data_d;
    end
  end

  assign mem_we    = (op_q == OP_WRITE);
  assign mem_wdata = wdat_q;

endmodule

// File: rtl/host_word_packer.sv
module host_word_packer
  import hwp_pkg::*;
#(
  parameter int HOST_W = 16,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              cfg_word24,
  input  logic              hst_cs,
  input  logic              hst_rd_stb,
  input  logic              hst_wr_stb,
  input  logic [HOST_W-1:0] hst_wdata,
  output logic              hst_ack,
  output logic [HOST_W-1:0] hst_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_done
);

  logic              stb;
  op_e               stb_op;
  pidx_t             total;
  logic              acc;
  op_e               acc_op;
  logic [HOST_W-1:0] acc_data;
  logic              busy_q;
  logic              pend_v_q;
  pidx_t             eff_idx;
  logic              is_last;
  pidx_t             cnt_q;
  logic              issue;
  logic              quick;
  logic              fill;
  logic              serve;
  logic              wr_load;
  logic [WORD_W-1:0] word_next;

  assign stb    = hst_cs && (hst_rd_stb || hst_wr_stb);
  assign stb_op = hst_wr_stb ? OP_WRITE : OP_READ;
  assign total  = piece_total(cfg_wide, cfg_word24);

  // Memory is touched by the last write piece or the first read piece.
  assign issue   = acc && ((acc_op == OP_WRITE) ? is_last : (eff_idx == '0));
  assign quick   = acc && !issue;
  assign fill    = busy_q && mem_done && !mem_we;
  assign serve   = quick && (acc_op == OP_READ);
  assign wr_load = acc && (acc_op == OP_WRITE);
  assign mem_req = busy_q;

  hwp_piece_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (hst_cs),
    .adv     (acc),
    .adv_op  (acc_op),
    .total   (total),
    .eff_idx (eff_idx),
    .is_last (is_last),
    .cnt_q   (cnt_q)
  );

  hwp_wr_pack #(.HOST_W(HOST_W), .WORD_W(WORD_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_load),
    .wide      (cfg_wide),
    .idx       (eff_idx),
    .wdata     (acc_data),
    .word_next (word_next)
  );

  hwp_rd_unpack #(.HOST_W(HOST_W), .WORD_W(WORD_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill      (fill),
    .mem_rdata (mem_rdata),
    .serve     (serve),
    .idx       (eff_idx),
    .wide      (cfg_wide),
    .rdata_q   (hst_rdata)
  );

  hwp_seq #(.HOST_W(HOST_W), .WORD_W(WORD_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .stb_op    (stb_op),
    .wdata     (hst_wdata),
    .issue     (issue),
    .quick     (quick),
    .mem_done  (mem_done),
    .word_next (word_next),
    .acc       (acc),
    .acc_op    (acc_op),
    .acc_data  (acc_data),
    .busy_q    (busy_q),
    .pend_v_q  (pend_v_q),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .ack_q     (hst_ack)
  );

endmodule

// File: rtl/hwp_checker.sv
module hwp_checker #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_cs,
  input logic              hst_ack,
  input logic              mem_req,
  input logic              mem_we,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_done,
  input logic [1:0]        cnt,
  input logic [1:0]        total,
  input logic              stb,
  input logic              pend_v
);

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_we) && $stable(mem_wdata))); // R3

  AST_DONE_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_done) |=> hst_ack); // R7

  AST_NO_ACK_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !hst_ack); // R7

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != 2'd0) |-> (cnt < total)); // R1

  AST_CS_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_cs |=> (cnt == 2'd0)); // R8

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && stb && !pend_v) |=> pend_v); // R9

endmodule

bind host_word_packer hwp_checker #(.WORD_W(WORD_W)) u_hwp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hst_cs    (hst_cs),
  .hst_ack   (hst_ack),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_done  (mem_done),
  .cnt       (cnt_q),
  .total     (total),
  .stb       (stb),
  .pend_v    (pend_v_q)
);

// File: tb/host_word_packer_tb_top.sv
module host_word_packer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide = 1'b0;
  logic        cfg_word24 = 1'b1;
  logic        hst_cs = 1'b1;
  logic        hst_rd_stb = 1'b0;
  logic        hst_wr_stb = 1'b0;
  logic [15:0] hst_wdata = '0;
  logic        hst_ack;
  logic [15:0] hst_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [23:0] mem_wdata;
  logic [23:0] mem_rdata;
  logic        mem_done = 1'b0;

  always #2 clk = ~clk;

  host_word_packer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_word24(cfg_word24),
    .hst_cs(hst_cs), .hst_rd_stb(hst_rd_stb), .hst_wr_stb(hst_wr_stb),
    .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_rdata(hst_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 0;
  int          n_req = 0;
  int          n_wr = 0;
  int          mem_lat = 1;
  int          lat_left = 0;
  bit          req_seen = 0;
  logic [23:0] wr_log = '0;
  logic [23:0] rd_word = '0;

  assign mem_rdata = rd_word;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: answers each request after mem_lat cycles.
  always @(negedge clk) begin
    if (mem_done) begin
      mem_done <= 1'b0;
    end else if (mem_req) begin
      if (!req_seen) begin
        req_seen = 1;
        lat_left = mem_lat;
        n_req++;
      end
      if (lat_left == 0) begin
        mem_done <= 1'b1;
        req_seen = 0;
        if (mem_we) begin
          wr_log = mem_wdata;
          n_wr++;
        end
      end else begin
        lat_left--;
      end
    end
  end

  function automatic int npieces(input bit wide, input bit w24);
    if (wide) return w24 ? 2 : 1;
    return w24 ? 3 : 2;
  endfunction

  function automatic logic [23:0] wr_contrib(input bit wide, input int k, input logic [15:0] d);
    if (!wide) return 24'(d[7:0]) << (8 * k);
    if (k == 0) return {8'h00, d};
    return {d[15:8], 16'h0000};
  endfunction

  function automatic logic [15:0] rd_piece(input bit wide, input int k, input logic [23:0] w);
    if (!wide) return {8'h00, w[8*k +: 8]};
    if (k == 0) return w[15:0];
    return {w[23:16], 8'h00};
  endfunction

  task automatic access(input bit we, input logic [15:0] d, output int waited, output logic [15:0] rd);
    @(negedge clk);
    hst_wr_stb = we;
    hst_rd_stb = !we;
    hst_wdata  = d;
    @(negedge clk);
    hst_wr_stb = 1'b0;
    hst_rd_stb = 1'b0;
    waited = 0;
    while (!hst_ack && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 200) chk(0, "R7 ack timeout", 32'(waited), 32'd0);
    rd = hst_rdata;
  endtask

  task automatic wr_word(input string tag);
    int          p;
    int          w;
    int          r0;
    int          w0;
    logic [15:0] d;
    logic [15:0] rd;
    logic [23:0] exp;
    p = npieces(cfg_wide, cfg_word24);
    exp = '0;
    for (int k = 0; k < p; k++) begin
      d = 16'($urandom);
      exp |= wr_contrib(cfg_wide, k, d);
      r0 = n_req;
      w0 = n_wr;
      access(1'b1, d, w, rd);
      if (k < p - 1) begin
        chk(w == 0, {tag, " R6 early piece ack"}, 32'(w), 32'd0);
        chk(n_req == r0, {tag, " R1 R3 no write before last piece"}, 32'(n_req), 32'(r0));
      end else begin
        chk(w >= 1, {tag, " R7 final piece waits for memory"}, 32'(w), 32'd1);
        chk(n_wr == w0 + 1, {tag, " R3 one write per word"}, 32'(n_wr), 32'(w0 + 1));
        chk(wr_log == exp, {tag, " R2 assembled word"}, 32'(wr_log), 32'(exp));
      end
    end
  endtask

  task automatic rd_word_seq(input string tag, input int first);
    int          p;
    int          w;
    int          r0;
    logic [15:0] rd;
    p = npieces(cfg_wide, cfg_word24);
    for (int k = first; k < p; k++) begin
      r0 = n_req;
      access(1'b0, 16'h0, w, rd);
      if (k == 0) begin
        chk(n_req == r0 + 1, {tag, " R4 one read on first piece"}, 32'(n_req), 32'(r0 + 1));
        chk(w >= 1, {tag, " R7 first read piece waits"}, 32'(w), 32'd1);
      end else begin
        chk(n_req == r0, {tag, " R4 no read on later piece"}, 32'(n_req), 32'(r0));
        chk(w == 0, {tag, " R6 later read piece ack"}, 32'(w), 32'd0);
      end
      chk(rd == rd_piece(cfg_wide, k, rd_word), {tag, " R5 read lane"}, 32'(rd),
          32'(rd_piece(cfg_wide, k, rd_word)));
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R11 watchdog expired", 32'd0, 32'd1);
    report();
  end

  initial begin
    int          rnd;
    int          w;
    int          r0;
    int          w0;
    bit          saw;
    logic [15:0] rd;
    logic [15:0] d3;
    logic [15:0] d4;
    logic [15:0] d5;
    rnd = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0, "R11 no request after reset", 32'(mem_req), 32'd0);
    chk(hst_ack == 1'b0, "R11 no ack after reset", 32'(hst_ack), 32'd0);
    // Directed: every configuration, write then read
    for (int c = 0; c < 4; c++) begin
      cfg_wide = c[1];
      cfg_word24 = c[0];
      wr_word("dir");
      rd_word = 24'h5A_C3_81 ^ 24'(c);
      rd_word_seq("dir", 0);
    end
    // R8: chip-select drop mid-word, then ignored strobe
    cfg_wide = 1'b0;
    cfg_word24 = 1'b1;
    access(1'b1, 16'h00EE, w, rd);
    @(negedge clk);
    hst_cs = 1'b0;
    r0 = n_req;
    hst_wr_stb = 1'b1;
    @(negedge clk);
    hst_wr_stb = 1'b0;
    saw = 0;
    repeat (5) begin
      @(negedge clk);
      if (hst_ack) saw = 1;
    end
    chk(!saw, "R8 strobe ignored without chip select", 32'(saw), 32'd0);
    chk(n_req == r0, "R8 no request without chip select", 32'(n_req), 32'(r0));
    hst_cs = 1'b1;
    wr_word("R8 after cs drop");
    // R10: read interrupts a partial write
    access(1'b1, 16'h0077, w, rd);
    rd_word = 24'hA1B2C3;
    rd_word_seq("R10 read restarts", 0);
    wr_word("R10 write after read");
    // R9: strobe while the posted write is outstanding
    mem_lat = 4;
    access(1'b1, 16'h0011, w, rd);
    access(1'b1, 16'h0022, w, rd);
    w0 = n_wr;
    d3 = 16'h0033;
    d4 = 16'h0044;
    d5 = 16'h0055;
    @(negedge clk);
    hst_wr_stb = 1'b1;
    hst_wdata = d3;
    @(negedge clk);
    hst_wr_stb = 1'b0;
    chk(mem_req == 1'b1, "R9 write outstanding", 32'(mem_req), 32'd1);
    hst_wr_stb = 1'b1;
    hst_wdata = 16'h0044;
    @(negedge clk);
    hst_wr_stb = 1'b0;
    hst_wdata = 16'h0;
    w = 0;
    while (!hst_ack && w < 200) begin
      @(negedge clk);
      w++;
    end
    chk(n_wr == w0 + 1 && wr_log == 24'h332211, "R9 posted word", 32'(wr_log), 32'h332211);
    r0 = n_req;
    @(negedge clk);
    chk(hst_ack == 1'b1, "R9 held piece acknowledged after write", 32'(hst_ack), 32'd1);
    chk(n_req == r0, "R9 held piece issues no request", 32'(n_req), 32'(r0));
    access(1'b1, 16'h0066, w, rd);
    access(1'b1, 16'h0088, w, rd);
    chk(wr_log == {8'h88, 8'h66, d4[7:0]}, "R9 held piece lands in lane 0", 32'(wr_log),
        32'({8'h88, 8'h66, d4[7:0]}));
    // Constrained random words
    for (int i = 0; i < 150; i++) begin
      mem_lat = int'($urandom_range(0, 3));
      cfg_wide = 1'($urandom);
      cfg_word24 = 1'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        wr_word("rand");
      end else begin
        rd_word = 24'($urandom);
        rd_word_seq("rand", 0);
      end
    end
    report();
  end

endmodule